// File: doc/BRIEF.md
# Banked Processor Register File

This block holds the general-purpose registers of a processor core that has several privilege modes. Some registers are replaced by private copies depending on the current mode. The mode is the low five bits of the current status word, which the block holds itself. Two combinational read ports and one write port always address the sixteen registers visible in the current mode. Register 15 and registers 0 to 7 are the same physical storage in every mode.

The fast-interrupt mode has private copies of registers 8 to 14. The interrupt, supervisor, abort and undefined modes each have private copies of registers 13 and 14 only. User and system modes share one set of registers. Any mode value that the lookup does not recognise falls into a dummy bank. In that bank, registers 8 to 14 read as zero and writes to them are lost. A physical copy exists for every banked register, so a mode change is only a change of address decode and never moves data.

The five exception modes each also have a saved-status word. A move-to-status operation writes either the current or the saved status word under a four-bit byte mask. A mode change written into the current status word takes effect on the next clock edge.

Top module: `banked_regfile`

## Requirements
- R1: After reset the current status word is 0x00000013 (supervisor), every register and every saved-status word is zero, and `priv` is high.
- R2: The mode field sw[4:0] selects a bank as follows. User: 0x00 and 0x10. Fast interrupt: 0x01 and 0x11. Interrupt: 0x02 and 0x12. Supervisor: 0x03 and 0x13. Abort: 0x17. Undefined: 0x1B. System: 0x1F. Every other value selects the dummy bank.
- R3: Registers 0 to 7 and register 15 are one set, shared by all modes including the dummy bank.
- R4: In fast-interrupt mode, registers 8 to 14 are private copies. Outside that mode, registers 8 to 12 are one set shared by every non-dummy bank, and leaving fast-interrupt mode restores their earlier values.
- R5: The interrupt, supervisor, abort and undefined banks each have private registers 13 and 14. System mode uses the user copies of these registers.
- R6: In the dummy bank, registers 8 to 14 read as zero and writes to them have no effect in any bank.
- R7: In the user, system and dummy banks, `sr_saved` returns the current status word, and a saved-status write changes nothing.
- R8: Byte mask bit k enables a write of byte k of the status word: bit 0 covers [7:0], bit 1 [15:8], bit 2 [23:16] and bit 3 [31:24]. Unmasked bytes keep their value. This holds for both the current and the saved status word.
- R9: In the user bank, a current-status write changes only bits [31:24], whatever the mask.
- R10: A mode change from a status write applies to reads and writes from the next cycle on. A register write in the same cycle goes to the old bank.
- R11: `priv` is high exactly when sw[1:0] is nonzero.
- R12: Both read ports return the value for their own select in the same cycle, independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_sel | input | 4 | Read port A register number |
| rd_a_val | output | 32 | Read port A data |
| rd_b_sel | input | 4 | Read port B register number |
| rd_b_val | output | 32 | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_sel | input | 4 | Register write number |
| wr_val | input | 32 | Register write data |
| psr_we | input | 1 | Status write enable |
| psr_saved | input | 1 | 1: target saved-status word, 0: current status word |
| psr_mask | input | 4 | Byte enable mask for the status write |
| psr_val | input | 32 | Status write data |
| sr_now | output | 32 | Current status word |
| sr_saved | output | 32 | Saved-status word of current bank, or current word if none |
| priv | output | 1 | Privileged mode indicator |

## Verification
A sweep visits all 32 mode values, each from a fresh supervisor state with known r9 and r13, and shows which bank the lookup picked, the dummy bank included. A directed swap into fast-interrupt mode and back separates the private copies from the shared ones and checks that a write in the switching cycle lands in the old bank. A user-mode full-mask write checks that only the flag byte changes. Long random runs mix register writes, masked status writes with mode values from every bank, and periodic resets. A behavioural model that swaps copies on each mode change is compared against the design every cycle, so a mix-up between banks shows up as a wrong read value.

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      rd_a_sel,
  output logic [XLEN-1:0] rd_a_val,
  input  logic [3:0]      rd_b_sel,
  output logic [XLEN-1:0] rd_b_val,
  input  logic            wr_en,
  input  logic [3:0]      wr_sel,
  input  logic [XLEN-1:0] wr_val,
  input  logic            psr_we,
  input  logic            psr_saved,
  input  logic [3:0]      psr_mask,
  input  logic [XLEN-1:0] psr_val,
  output logic [XLEN-1:0] sr_now,
  output logic [XLEN-1:0] sr_saved,
  output logic            priv
);
  localparam int NLO = 8;
  localparam int NHI = 7;
  localparam int NEX = 4;
  localparam int NSP = 5;
  localparam int BW  = XLEN / 4;
  localparam logic [XLEN-1:0] RST_SW = XLEN'(5'h13);

  localparam logic [2:0] BK_USR = 3'd0, BK_FIQ = 3'd1, BK_IRQ = 3'd2, BK_SVC = 3'd3,
                         BK_ABT = 3'd4, BK_UND = 3'd5, BK_SYS = 3'd6, BK_DUM = 3'd7;

  function automatic logic [2:0] bank_of(input logic [4:0] m);
    case (m)
      5'h00, 5'h10: bank_of = BK_USR;
      5'h01, 5'h11: bank_of = BK_FIQ;
      5'h02, 5'h12: bank_of = BK_IRQ;
      5'h03, 5'h13: bank_of = BK_SVC;
      5'h17:        bank_of = BK_ABT;
      5'h1B:        bank_of = BK_UND;
      5'h1F:        bank_of = BK_SYS;
      default:      bank_of = BK_DUM;
    endcase
  endfunction

  logic [XLEN-1:0] lo_q  [NLO];
  logic [XLEN-1:0] shr_q [NHI];
  logic [XLEN-1:0] fiq_q [NHI];
  logic [XLEN-1:0] ex13_q[NEX];
  logic [XLEN-1:0] ex14_q[NEX];
  logic [XLEN-1:0] sp_q  [NSP];
  logic [XLEN-1:0] pc_q, sw_q;

  logic [2:0] cur_bk;
  logic [1:0] exi;
  logic [2:0] spi;
  logic       is_ex, has_sp;
  assign cur_bk = bank_of(sw_q[4:0]);
  assign is_ex  = (cur_bk >= BK_IRQ) && (cur_bk <= BK_UND);
  assign has_sp = (cur_bk >= BK_FIQ) && (cur_bk <= BK_UND);
  assign exi    = 2'(cur_bk - BK_IRQ);
  assign spi    = cur_bk - BK_FIQ;

  assign sr_now   = sw_q;
  assign sr_saved = has_sp ? sp_q[spi] : sw_q;
  assign priv     = |sw_q[1:0];

  logic [3:0]      sel  [2];
  logic [XLEN-1:0] rval [2];
  assign sel[0]   = rd_a_sel;
  assign sel[1]   = rd_b_sel;
  assign rd_a_val = rval[0];
  assign rd_b_val = rval[1];

  for (genvar p = 0; p < 2; p++) begin : g_rd
    logic [2:0] off;
    assign off = 3'(sel[p] - 4'd8);
    always_comb begin
      if (sel[p] < 4'd8)       rval[p] = lo_q[sel[p][2:0]];
      else if (sel[p] == 4'd15) rval[p] = pc_q;
      else if (cur_bk == BK_FIQ) rval[p] = fiq_q[off];
      else if (cur_bk == BK_DUM) rval[p] = '0;
      else if (is_ex && sel[p] == 4'd13) rval[p] = ex13_q[exi];
      else if (is_ex && sel[p] == 4'd14) rval[p] = ex14_q[exi];
      else                       rval[p] = shr_q[off];
    end
  end

  logic [3:0]      eff_mask;
  logic [XLEN-1:0] bit_mask, psr_old, psr_new;
  assign eff_mask = (!psr_saved && cur_bk == BK_USR) ? (psr_mask & 4'b1000) : psr_mask;
  for (genvar k = 0; k < 4; k++) begin : g_bm
    assign bit_mask[k*BW +: BW] = {BW{eff_mask[k]}};
  end
  assign psr_old = psr_saved ? sr_saved : sw_q;
  assign psr_new = (psr_old & ~bit_mask) | (psr_val & bit_mask);

  logic [2:0] w_off;
  assign w_off = 3'(wr_sel - 4'd8);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NLO; i++) lo_q[i] <= '0;
      for (int i = 0; i < NHI; i++) begin
        shr_q[i] <= '0;
        fiq_q[i] <= '0;
      end
      for (int i = 0; i < NEX; i++) begin
        ex13_q[i] <= '0;
        ex14_q[i] <= '0;
      end
      for (int i = 0; i < NSP; i++) sp_q[i] <= '0;
      pc_q <= '0;
      sw_q <= RST_SW;
    end else begin
      if (wr_en) begin
        if (wr_sel < 4'd8)         lo_q[wr_sel[2:0]] <= wr_val;
        else if (wr_sel == 4'd15)  pc_q <= wr_val;
        else if (cur_bk == BK_FIQ) fiq_q[w_off] <= wr_val;
        else if (cur_bk == BK_DUM) ;
        else if (is_ex && wr_sel == 4'd13) ex13_q[exi] <= wr_val;
        else if (is_ex && wr_sel == 4'd14) ex14_q[exi] <= wr_val;
        else                       shr_q[w_off] <= wr_val;
      end
      if (psr_we) begin
        if (!psr_saved)  sw_q <= psr_new;
        else if (has_sp) sp_q[spi] <= psr_new;
      end
    end
  end

  assert_user_flags_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (psr_we && !psr_saved && cur_bk == BK_USR) |=> (sr_now[23:0] == $past(sr_now[23:0])));

  assert_sw_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(psr_we && !psr_saved) |=> $stable(sr_now));

  assert_empty_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (psr_we && psr_mask == 4'd0) |=> ($stable(sr_now) && $stable(sr_saved)));

  assert_no_saved_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (psr_we && psr_saved && !has_sp) |=> $stable(sr_saved));

  assert_dummy_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_bk == BK_DUM && rd_a_sel >= 4'd8 && rd_a_sel <= 4'd14) |-> (rd_a_val == '0));

  assert_priv_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(psr_we && !psr_saved) |=> (priv == $past(priv)));
endmodule

// File: tb/sim_banked_regfile.sv
module sim_banked_regfile;
  logic        clk = 0, rst_n = 0;
  logic [3:0]  rd_a_sel = 0, rd_b_sel = 0, wr_sel = 0, psr_mask = 0;
  logic [31:0] rd_a_val, rd_b_val, wr_val = 0, psr_val = 0, sr_now, sr_saved;
  logic        wr_en = 0, psr_we = 0, psr_saved = 0, priv;

  banked_regfile u0 (.clk, .rst_n, .rd_a_sel, .rd_a_val, .rd_b_sel, .rd_b_val,
    .wr_en, .wr_sel, .wr_val, .psr_we, .psr_saved, .psr_mask, .psr_val,
    .sr_now, .sr_saved, .priv);

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] cur [16];
  logic [31:0] usave [16];
  logic [31:0] fsave [16];
  logic [31:0] s13 [8];
  logic [31:0] s14 [8];
  logic [31:0] spsr [8];
  logic [31:0] cpsr;

  function automatic int bk(input logic [4:0] m);
    case (m)
      5'h00, 5'h10: return 0;
      5'h01, 5'h11: return 1;
      5'h02, 5'h12: return 2;
      5'h03, 5'h13: return 3;
      5'h17: return 4;
      5'h1B: return 5;
      5'h1F: return 6;
      default: return 7;
    endcase
  endfunction

  function automatic int grp(input int b);
    return (b == 6) ? 0 : b;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 16; i++) begin cur[i] = 0; usave[i] = 0; fsave[i] = 0; end
    for (int i = 0; i < 8; i++) begin s13[i] = 0; s14[i] = 0; spsr[i] = 0; end
    cpsr = 32'h13;
  endtask

  task automatic swap(input int ob, input int nb);
    if (ob == nb) return;
    if (ob == 1) for (int i = 8; i < 15; i++) fsave[i] = cur[i];
    else if (ob != 7) begin
      for (int i = 8; i < 13; i++) usave[i] = cur[i];
      s13[grp(ob)] = cur[13]; s14[grp(ob)] = cur[14];
    end
    if (nb == 1) for (int i = 8; i < 15; i++) cur[i] = fsave[i];
    else if (nb == 7) for (int i = 8; i < 15; i++) cur[i] = 0;
    else begin
      for (int i = 8; i < 13; i++) cur[i] = usave[i];
      cur[13] = s13[grp(nb)]; cur[14] = s14[grp(nb)];
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n, input logic [3:0] m);
    logic [31:0] r = o;
    for (int k = 0; k < 4; k++) if (m[k]) r[k*8 +: 8] = n[k*8 +: 8];
    return r;
  endfunction

  function automatic string rtag(input logic [3:0] idx);
    int b = bk(cpsr[4:0]);
    if (idx < 8 || idx == 15) return "R3";
    if (b == 7) return "R6";
    if (b == 1) return "R4";
    return "R5";
  endfunction

  task automatic chk(input string tg, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tg, what, got, exp);
    end
  endtask

  task automatic step(input bit r, input bit we, input logic [3:0] ws, input logic [31:0] wv,
                      input bit pwe, input bit ps, input logic [3:0] pm, input logic [31:0] pv,
                      input logic [3:0] ra, input logic [3:0] rb, input string ov);
    int b;
    @(negedge clk);
    rst_n = !r; wr_en = we; wr_sel = ws; wr_val = wv;
    psr_we = pwe; psr_saved = ps; psr_mask = pm; psr_val = pv;
    rd_a_sel = ra; rd_b_sel = rb;
    #1;
    b = bk(cpsr[4:0]);
    if (!r) begin
      chk(ov != "" ? ov : rtag(ra), "rd_a", rd_a_val, cur[ra]);
      chk(ov != "" ? ov : "R12", "rd_b", rd_b_val, cur[rb]);
      chk(ov != "" ? ov : (b == 0 ? "R9" : "R8"), "sr_now", sr_now, cpsr);
      chk(ov != "" ? ov : ((b >= 1 && b <= 5) ? "R8" : "R7"), "sr_saved", sr_saved,
          (b >= 1 && b <= 5) ? spsr[b] : cpsr);
      chk(ov != "" ? ov : "R11", "priv", {31'd0, priv}, {31'd0, |cpsr[1:0]});
    end
    @(posedge clk);
    if (r) model_reset();
    else begin
      if (we && !(b == 7 && ws >= 8 && ws <= 14)) cur[ws] = wv;
      if (pwe) begin
        if (ps) begin
          if (b >= 1 && b <= 5) spsr[b] = merge(spsr[b], pv, pm);
        end else begin
          logic [31:0] nc = merge(cpsr, pv, (b == 0) ? (pm & 4'b1000) : pm);
          swap(b, bk(nc[4:0]));
          cpsr = nc;
        end
      end
    end
  endtask

  task automatic idle(input logic [3:0] ra, input logic [3:0] rb, input string ov);
    step(0, 0, 0, 0, 0, 0, 0, 0, ra, rb, ov);
  endtask

  function automatic logic [4:0] pick_mode();
    case ($urandom % 10)
      0: return 5'h10; 1: return 5'h00; 2: return 5'h11; 3: return 5'h12;
      4: return 5'h13; 5: return 5'h17; 6: return 5'h1B; 7: return 5'h1F;
      8: return 5'h05; default: return 5'($urandom);
    endcase
  endfunction

  initial begin
    #1500000;
    if (!done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
    for (int i = 0; i < 16; i++) idle(4'(i), 4'(15 - i), "R1");

    step(0, 1, 13, 32'h5555_0013, 0, 0, 0, 0, 0, 0, "R10");
    step(0, 1, 9, 32'h0000_0909, 0, 0, 0, 0, 0, 0, "R10");
    step(0, 1, 13, 32'hAAAA_1313, 1, 0, 4'b0001, 32'h11, 13, 9, "R10");
    idle(13, 9, "R10");
    step(0, 1, 9, 32'hF1F1_0009, 0, 0, 0, 0, 9, 13, "R4");
    step(0, 0, 0, 0, 1, 0, 4'b0001, 32'h13, 9, 13, "R4");
    idle(9, 13, "R4");
    idle(13, 14, "R5");

    step(0, 0, 0, 0, 1, 0, 4'b0001, 32'h10, 0, 0, "R9");
    step(0, 0, 0, 0, 1, 0, 4'b1111, 32'hA5A5_A5A3, 0, 0, "R9");
    idle(13, 9, "R9");
    step(0, 0, 0, 0, 1, 1, 4'b1111, 32'h1234_5678, 0, 0, "R7");
    idle(0, 0, "R7");

    for (int m = 0; m < 32; m++) begin
      step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
      step(0, 1, 13, 32'h1300_0000 + m, 0, 0, 0, 0, 0, 0, "R2");
      step(0, 1, 9, 32'h0900_0000 + m, 0, 0, 0, 0, 0, 0, "R2");
      step(0, 0, 0, 0, 1, 0, 4'b0001, 32'(m), 13, 9, "R2");
      step(0, 1, 10, 32'hDEAD_0000 + m, 1, 1, 4'b0011, 32'hCAFE_0000 + m, 13, 9, "R2");
      idle(13, 10, "R2");
      idle(14, 9, "R2");
    end

    step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
    for (int c = 0; c < 6000; c++) begin
      bit r = (c % 64) == 63;
      logic [31:0] pv = {$urandom} & 32'hFFFF_FFE0;
      pv[4:0] = pick_mode();
      step(r, ($urandom % 3) != 0, 4'($urandom), $urandom,
           ($urandom % 4) == 0, ($urandom % 3) == 0, 4'($urandom) | 4'(($urandom % 2)), pv,
           4'($urandom), 4'($urandom), "");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule